// File: doc/BRIEF.md
# Shift-Based LMS Weight Updater

This block keeps the coefficient set of a four-tap adaptive FIR filter and updates it once per sample using a least-mean-square rule in which no multiplier appears. The product of the step size, the error and each delayed input sample is approximated by shifting. The error magnitude is reduced to the position of its highest set bit. That position becomes a shift count shared by one barrel shifter per tap. The sign of the error then decides whether each shifted sample is added to or subtracted from its weight.

The user presents the error, the four most recent input samples (newest in tap 0), and a small step exponent, and pulses a one-cycle update strobe. The step size is 2^-i divided by the tap count. The `i` part and the division by the tap count are applied as a fixed pre-shift of the samples. The data-dependent part, taken from the error, is applied by the barrel shifters. Registers sit before and after the final weight addition, so the longest path holds one adder. The weights are always visible at the output, so the filter datapath and the next update both use them.

Top module: `lmsw_update_unit`

## Requirements
- R1: A synchronous active-high reset clears all four weights to zero.
- R2: While the strobe is low, the weights keep their values whatever the error, step and sample inputs do.
- R3: A strobe with a positive error adds to weight k the value x_k >>> (lz + 2 + i). Here lz = 15 - p, and p is the bit index of the highest one in the 16-bit error magnitude. Tap k occupies bits [16k+15:16k] of the sample and weight buses.
- R4: A strobe with a negative error (bit 15 set) subtracts the same shifted sample. Its magnitude is the two's-complement negation, so 0x8000 has magnitude 0x8000.
- R5: A strobe with an error of exactly zero leaves every weight unchanged.
- R6: Only the highest one of the error magnitude matters. Errors 0x01FF and 0x0100 give identical increments.
- R7: Each unit of the 3-bit step exponent adds one position to the shift.
- R8: Shifts are arithmetic on sign-extended samples. A negative sample never shifts to zero (-7 >>> 3 is -1), and any shift of 16 or more yields 0 or -1.
- R9: Weight arithmetic wraps in 16-bit two's complement with no saturation.
- R10: Strobes on consecutive cycles are each applied, one per cycle, in order.
- R11: A strobe sampled on clock edge E changes the weights on edge E+2, and not on edge E+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | One-cycle update strobe |
| err_i | input | 16 | Signed error e(n) |
| step_i | input | 3 | Step exponent i |
| x_i | input | 64 | Four signed samples, x(n) in bits 15:0 up to x(n-3) in bits 63:48 |
| w_o | output | 64 | Four signed weights, tap k in bits 16k+15:16k |

## Verification
Because the updater is pipelined, one update can be adding its increments into the weight registers in the same cycle that the next update decodes its error and pre-shifts its samples. The bench provokes this overlap by holding the strobe high for two consecutive cycles with the same inputs. It judges the result by reading the weight one cycle after the first update lands and again a cycle later, expecting one step and then two. A second overlap case uses a zero-error strobe that lands while the weights are idle. That weight is watched across the cycles where an increment would have appeared.

// File: rtl/lmsw_pkg.sv
package lmsw_pkg;

    typedef enum logic {
        ACC_ADD = 1'b0,
        ACC_SUB = 1'b1
    } acc_op_e;

endpackage

// File: rtl/lmsw_lead_decode.sv
module lmsw_lead_decode #(
    parameter int EW = 16,
    localparam int TW = $clog2(EW)
) (
    input  logic [EW-1:0] err_i,
    output logic          neg_o,
    output logic          zero_o,
    output logic [EW-1:0] mag_o,
    output logic [TW-1:0] lz_o
);

    always_comb begin
        int top_bit;
        neg_o  = err_i[EW-1];
        mag_o  = neg_o ? (EW'(0) - err_i) : err_i;
        zero_o = (err_i == '0);
        top_bit = 0;
        for (int b = 0; b < EW; b++) begin
            if (mag_o[b]) top_bit = b;
        end
        lz_o = TW'(EW - 1 - top_bit);
    end

endmodule

// File: rtl/lmsw_barrel_shift.sv
module lmsw_barrel_shift #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 16,
    parameter int SH_W  = 4
) (
    input  logic signed [IN_W-1:0]  din,
    input  logic        [SH_W-1:0]  sh,
    output logic signed [OUT_W-1:0] dout
);

    logic signed [OUT_W-1:0] stg [SH_W+1];

    assign stg[0] = OUT_W'(din);

    for (genvar g = 0; g < SH_W; g++) begin : g_stage
        assign stg[g+1] = sh[g] ? (stg[g] >>> (2 ** g)) : stg[g];
    end

    assign dout = stg[SH_W];

endmodule

// File: rtl/lmsw_weight_cell.sv
module lmsw_weight_cell
    import lmsw_pkg::*;
#(
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  acc_op_e       op_i,
    input  logic [WW-1:0] inc_i,
    output logic [WW-1:0] w_o
);

    logic [WW-1:0] w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (en_i) begin
            w_d = (op_i == ACC_SUB) ? (w_q - inc_i) : (w_q + inc_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) w_q <= '0;
        else     w_q <= w_d;
    end

    assign w_o = w_q;

    // R2: with no pending increment the weight holds
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(w_q));

    // R5: a zero increment leaves the weight unchanged
    a_r5_zero_inc_hold: assert property (@(posedge clk) disable iff (rst)
        (en_i && inc_i == '0) |=> $stable(w_q));

endmodule

// File: rtl/lmsw_update_unit.sv
module lmsw_update_unit
    import lmsw_pkg::*;
#(
    parameter int NTAP = 4,
    parameter int SW   = 16,
    parameter int EW   = 16,
    parameter int WW   = 16,
    parameter int IW   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_i,
    input  logic [EW-1:0]      err_i,
    input  logic [IW-1:0]      step_i,
    input  logic [NTAP*SW-1:0] x_i,
    output logic [NTAP*WW-1:0] w_o
);

    localparam int LOG2N = $clog2(NTAP);
    localparam int TW    = $clog2(EW);
    localparam int PW    = $clog2((2 ** IW) + LOG2N);

    typedef struct packed {
        logic                      s1_vld;
        acc_op_e                   s1_op;
        logic                      s1_zero;
        logic [TW-1:0]             s1_lz;
        logic [NTAP-1:0][SW-1:0]   s1_pre;
        logic                      s2_vld;
        acc_op_e                   s2_op;
        logic [NTAP-1:0][WW-1:0]   s2_inc;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic          dec_neg, dec_zero;
    logic [EW-1:0] dec_mag;
    logic [TW-1:0] dec_lz;
    logic [PW-1:0] pre_sh;

    logic [NTAP-1:0][SW-1:0] pre_w;
    logic [NTAP-1:0][WW-1:0] inc_w;

    lmsw_lead_decode #(.EW(EW)) u_dec (
        .err_i  (err_i),
        .neg_o  (dec_neg),
        .zero_o (dec_zero),
        .mag_o  (dec_mag),
        .lz_o   (dec_lz)
    );

    assign pre_sh = PW'(step_i) + PW'(LOG2N);

    for (genvar k = 0; k < NTAP; k++) begin : g_tap
        lmsw_barrel_shift #(.IN_W(SW), .OUT_W(SW), .SH_W(PW)) u_pre (
            .din  (x_i[k*SW +: SW]),
            .sh   (pre_sh),
            .dout (pre_w[k])
        );

        lmsw_barrel_shift #(.IN_W(SW), .OUT_W(WW), .SH_W(TW)) u_scale (
            .din  (pipe_q.s1_pre[k]),
            .sh   (pipe_q.s1_lz),
            .dout (inc_w[k])
        );

        lmsw_weight_cell #(.WW(WW)) u_cell (
            .clk   (clk),
            .rst   (rst),
            .en_i  (pipe_q.s2_vld),
            .op_i  (pipe_q.s2_op),
            .inc_i (pipe_q.s2_inc[k]),
            .w_o   (w_o[k*WW +: WW])
        );
    end

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.s1_vld = upd_i;
        if (upd_i) begin
            pipe_d.s1_op   = dec_neg ? ACC_SUB : ACC_ADD;
            pipe_d.s1_zero = dec_zero;
            pipe_d.s1_lz   = dec_lz;
            pipe_d.s1_pre  = pre_w;
        end
        pipe_d.s2_vld = pipe_q.s1_vld;
        if (pipe_q.s1_vld) begin
            pipe_d.s2_op  = pipe_q.s1_op;
            pipe_d.s2_inc = pipe_q.s1_zero ? '0 : inc_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    // R11: a strobe enters the first stage on the next edge
    a_r11_capture: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> pipe_q.s1_vld);

    // R11: the first stage always advances to the addition stage
    a_r11_forward: assert property (@(posedge clk) disable iff (rst)
        pipe_q.s1_vld |=> pipe_q.s2_vld);

    // R2: no strobe, no work in the pipeline
    a_r2_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> !pipe_q.s1_vld);

    // R5: a zero error yields all-zero increments
    a_r5_zero_error: assert property (@(posedge clk) disable iff (rst)
        (pipe_q.s1_vld && pipe_q.s1_zero) |=> (pipe_q.s2_inc == '0));

    // R6: the decoded count points at the highest one of the magnitude
    a_r6_lead_one: assert property (@(posedge clk) disable iff (rst)
        !dec_zero |-> ((dec_mag >> (EW - 1 - int'(dec_lz))) == EW'(1)));

endmodule

// File: tb/lmsw_update_unit_test.sv
module lmsw_update_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_i = 1'b0;
    logic [15:0] err_i = '0;
    logic [2:0]  step_i = '0;
    logic [63:0] x_i = '0;
    logic [63:0] w_o;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mw [4];

    localparam logic [15:0] T_ERR [8] = '{16'h1234, 16'hF000, 16'h0001, 16'h7FFF,
                                          16'h8000, 16'h0000, 16'hFFFF, 16'h0400};
    localparam logic [2:0]  T_STP [8] = '{3'd0, 3'd1, 3'd0, 3'd2, 3'd0, 3'd3, 3'd7, 3'd1};
    localparam logic [63:0] T_X   [8] = '{64'h1000_F000_0123_8000, 64'h7FFF_0001_FFFF_4000,
                                          64'hFFFB_0005_8000_7FFF, 64'h2000_E000_0040_FFC0,
                                          64'h0100_0200_0300_0400, 64'hAAAA_5555_1111_2222,
                                          64'h7FFF_8000_7FFF_8000, 64'hC000_3FFF_0800_F800};

    always #(CLK_PERIOD/2) clk = ~clk;

    lmsw_update_unit uut (
        .clk    (clk),
        .rst    (rst),
        .upd_i  (upd_i),
        .err_i  (err_i),
        .step_i (step_i),
        .x_i    (x_i),
        .w_o    (w_o)
    );

    function automatic logic [15:0] wt(int k);
        return w_o[k*16 +: 16];
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, $signed(act), $signed(exp));
        end
    endtask

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    // strobe held for cnt cycles; returns just after the last strobe edge
    task automatic strobe(logic [15:0] e, logic [2:0] s, logic [63:0] x, int cnt);
        err_i  = e;
        step_i = s;
        x_i    = x;
        upd_i  = 1'b1;
        wait_neg(cnt);
        upd_i  = 1'b0;
    endtask

    // spec model of one update applied to the bench's weight copy
    task automatic model_apply(logic [15:0] e, logic [2:0] s, logic [63:0] x);
        logic [15:0] mag;
        int top_bit;
        int sh;
        logic signed [15:0] xs;
        logic [15:0] inc;
        if (e == 16'h0) return;
        mag = e[15] ? (16'h0 - e) : e;
        top_bit = 0;
        for (int b = 0; b < 16; b++) if (mag[b]) top_bit = b;
        sh = (15 - top_bit) + 2 + int'(s);
        for (int k = 0; k < 4; k++) begin
            xs  = x[k*16 +: 16];
            inc = xs >>> sh;
            mw[k] = e[15] ? (mw[k] - inc) : (mw[k] + inc);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_neg(3);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) mw[k] = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        for (int k = 0; k < 4; k++) chk("R1 reset weight", wt(k), 16'h0);

        // R3 + R8 + R11: e=0x4000 (lz 1), i=0 -> shift 3
        strobe(16'h4000, 3'd0, {16'hFFF9, 16'h0007, 16'hFCE0, 16'h0320}, 1);
        wait_neg(1);
        chk("R11 no change on first edge", wt(0), 16'h0);
        wait_neg(1);
        chk("R3 add 800>>>3", wt(0), 16'd100);
        chk("R3 add -800>>>3", wt(1), 16'hFF9C);
        chk("R8 small positive to zero", wt(2), 16'h0);
        chk("R8 -7>>>3 is -1", wt(3), 16'hFFFF);

        // R4: negative error with the same magnitude undoes it
        strobe(16'hC000, 3'd0, {16'hFFF9, 16'h0007, 16'hFCE0, 16'h0320}, 1);
        wait_neg(2);
        for (int k = 0; k < 4; k++) chk("R4 subtract", wt(k), 16'h0);

        // R6: only the leading one counts
        strobe(16'h01FF, 3'd0, 64'h0000_0000_0000_1000, 1);
        wait_neg(2);
        chk("R6 error 0x01FF", wt(0), 16'd8);
        strobe(16'h0100, 3'd0, 64'h0000_0000_0000_1000, 1);
        wait_neg(2);
        chk("R6 error 0x0100", wt(0), 16'd16);

        // R7: step exponent adds one position
        strobe(16'h0100, 3'd1, 64'h0000_0000_0000_1000, 1);
        wait_neg(2);
        chk("R7 step one", wt(0), 16'd20);

        // R5: zero error changes nothing
        strobe(16'h0000, 3'd0, 64'h0000_0000_0000_1000, 1);
        wait_neg(2);
        chk("R5 zero error", wt(0), 16'd20);
        wait_neg(1);
        chk("R5 zero error later", wt(0), 16'd20);

        // R8: shift of 24 gives sign fill
        strobe(16'h0001, 3'd7, {16'h0, 16'h0005, 16'hFFFB, 16'h0}, 1);
        wait_neg(2);
        chk("R8 large shift negative", wt(1), 16'hFFFF);
        chk("R8 large shift positive", wt(2), 16'h0);

        // R10: back-to-back strobes, +100 each
        strobe(16'h4000, 3'd0, 64'h0000_0000_0000_0320, 2);
        wait_neg(1);
        chk("R10 first of pair", wt(0), 16'd120);
        wait_neg(1);
        chk("R10 second of pair", wt(0), 16'd220);

        // R2: inputs move, strobe low
        for (int c = 0; c < 5; c++) begin
            err_i  = 16'h4000 + 16'(c);
            step_i = 3'(c);
            x_i    = {4{16'h1111 * 16'(c + 1)}};
            wait_neg(1);
        end
        wait_neg(2);
        chk("R2 idle hold", wt(0), 16'd220);

        // R1 again, then R9 wrap
        do_reset();
        chk("R1 reset mid run", wt(0), 16'h0);
        for (int n = 0; n < 3; n++) begin
            strobe(16'h8000, 3'd0, 64'h0000_0000_0000_8000, 1);
            wait_neg(2);
        end
        chk("R9 before wrap", wt(0), 16'd24576);
        strobe(16'h8000, 3'd0, 64'h0000_0000_0000_8000, 1);
        wait_neg(2);
        chk("R9 wraps to 0x8000", wt(0), 16'h8000);

        // table walk against the spec model (R3 R4 R7 R8)
        do_reset();
        for (int t = 0; t < 8; t++) begin
            strobe(T_ERR[t], T_STP[t], T_X[t], 1);
            wait_neg(2);
            model_apply(T_ERR[t], T_STP[t], T_X[t]);
            for (int k = 0; k < 4; k++) chk("R3 R4 table entry", wt(k), mw[k]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule